// File: doc/BRIEF.md
# Transport-stream field sync generator

This block drives the vertical-sync input of a video capture port that carries an MPEG transport stream instead of pictures. The stream is treated as a frame of fixed-length lines. Each line holds a whole number of 188-byte packets, which is two packets or 376 bytes by default. The block counts accepted bytes into lines and lines into frames. From those counts it produces the VSYNC edges that the capture engine uses to open and close DMA windows.

Two output shapes can be selected. In pulse mode VSYNC is high for exactly the last line of every frame. In toggle mode VSYNC inverts every half frame, so that alternating fields are captured. The frame length N (usually 512 lines, which gives a window of 2 × 188 × 512 bytes) and the mode are sampled while the block is disabled and again at every frame wrap. A change made in mid-frame therefore never produces a short or distorted window.

An optional check compares the first byte of each packet slot with the transport sync byte 0x47. Any mismatch raises a sticky flag. The counters keep running and are never realigned. The current line index is given out as status.

Top module: `ts_field_sync`

## Requirements
- R1: After reset `vsync`, `line_idx` and `misalign` are 0. While `enable` is 0, `vsync` is 0, `line_idx` is 0, the byte position is 0, and bytes presented are not counted.
- R2: A line is PKT_BYTES × PKTS_PER_LINE accepted bytes (default 188 × 2 = 376). A byte is accepted when `enable` and `byte_vld` are both 1. `line_idx` increments on the edge that accepts the last byte of a line. Cycles with `byte_vld` at 0 change nothing.
- R3: `line_idx` wraps from N−1 to 0, where N is the effective frame length. A `cfg_lines` value of 0 or 1 is treated as 2.
- R4: Pulse mode (`cfg_mode` = 0). `vsync` becomes 1 on the edge that enters line N−1. It returns to 0 on the edge that wraps the frame to line 0.
- R5: Toggle mode (`cfg_mode` = 1). `vsync` inverts on the edge that enters line floor(N/2) and on the edge that wraps the frame to line 0.
- R6: `cfg_lines` and `cfg_mode` are captured while `enable` is 0 and on each frame wrap. The new values govern the frame that begins at that wrap. The wrap itself drives `vsync` to 0 in pulse mode and inverts it in toggle mode. Changes made in mid-frame have no effect until the next wrap.
- R7: When `chk_en` is 1, an accepted byte at a packet-start position other than 0x47 sets `misalign`. Packet-start positions are line offsets 0, PKT_BYTES, 2·PKT_BYTES, and so on. Once set, `misalign` stays 1 until reset. When `chk_en` is 0, no byte sets it.
- R8: A misaligned byte does not alter byte, line or VSYNC counting.
- R9: Every output reflects the accepted byte on the same clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Counting enable. When low, the counters are held at zero and the configuration is loaded |
| byte_vld | input | 1 | A stream byte is present on `byte_data` |
| byte_data | input | 8 | Stream byte |
| cfg_lines | input | LINE_IDX_W | Frame length N in lines |
| cfg_mode | input | 1 | 0 = pulse on last line, 1 = toggle every half frame |
| chk_en | input | 1 | Enable the sync-byte check |
| vsync | output | 1 | Vertical sync to the capture port |
| line_idx | output | LINE_IDX_W | Index of the line now being received |
| misalign | output | 1 | Sticky sync-byte mismatch flag |

## Verification
A byte position that slips by even one count moves every later line edge, so `line_idx` would disagree within one line of the fault. A wrong frame shadow shows up as a VSYNC edge on the wrong line, or a wrap at the wrong index, within one frame of the configuration change. A toggle state that is inverted or missed shows as `vsync` with the opposite polarity from the first half-frame edge onward. The sweep drives aligned streams through both modes and several frame lengths, including clamped and odd lengths. It compares `line_idx`, `vsync` and `misalign` after every byte and every idle cycle.

// File: rtl/ts_fs_pkg.sv
// Shared types for the transport-stream field sync generator.
// Assumes: nothing beyond IEEE 1800-2017.
package ts_fs_pkg;

    // Output shape of the vertical sync signal.
    typedef enum logic {
        VS_PULSE  = 1'b0,
        VS_TOGGLE = 1'b1
    } vs_mode_e;

    // Smallest frame length the block accepts; smaller requests are raised to it.
    localparam int unsigned MIN_LINES = 2;

endpackage

// File: rtl/ts_fs_byte_ctr.sv
// Byte position tracker: counts accepted bytes within a packet and packets
// within a line. It flags the byte that starts a packet and the byte that ends
// a line.
// Assumes: PKT_BYTES >= 2, PKTS_PER_LINE >= 1; counters are cleared while run is low.
module ts_fs_byte_ctr #(
    parameter int unsigned PKT_BYTES     = 188,
    parameter int unsigned PKTS_PER_LINE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic byte_acc,
    output logic pkt_start,
    output logic line_last
);
    localparam int unsigned POS_W = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PKT_BYTES - 1);

    logic [POS_W-1:0] pos_q;
    logic             pkt_last;
    logic             last_pkt_of_line;

    // Decode the position of the current byte within its packet.
    always_comb begin
        pkt_start = (pos_q == '0);
        pkt_last  = (pos_q == POS_LAST);
        line_last = pkt_last && last_pkt_of_line;
    end

    // Advance the byte position within a packet.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos_q <= '0;
        end else if (byte_acc) begin
            pos_q <= pkt_last ? '0 : pos_q + 1'b1;
        end
    end

    generate
        if (PKTS_PER_LINE == 1) begin : g_single_pkt
            // One packet per line: every packet end is a line end.
            always_comb last_pkt_of_line = 1'b1;
        end else begin : g_multi_pkt
            localparam int unsigned PK_W = $clog2(PKTS_PER_LINE);
            localparam logic [PK_W-1:0] PK_LAST = PK_W'(PKTS_PER_LINE - 1);
            logic [PK_W-1:0] pk_q;

            // Flag the final packet slot of the line.
            always_comb last_pkt_of_line = (pk_q == PK_LAST);

            // Advance the packet slot at each packet end.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    pk_q <= '0;
                end else if (byte_acc && pkt_last) begin
                    pk_q <= last_pkt_of_line ? '0 : pk_q + 1'b1;
                end
            end

            // R2
            pk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pk_q <= PK_LAST);
        end
    endgenerate

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_LAST);

    // R2
    pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !byte_acc) |=> $stable(pos_q));

endmodule

// File: rtl/ts_fs_line_ctr.sv
// Line counter with frame-boundary configuration shadow. It holds the line
// index and the frame length and mode in force. It publishes the index and the
// configuration that apply to the line being entered.
// Assumes: cfg inputs are loaded continuously while run is low and at each wrap.
module ts_fs_line_ctr
    import ts_fs_pkg::*;
#(
    parameter int unsigned LINE_IDX_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  line_adv,
    input  logic [LINE_IDX_W-1:0] cfg_lines,
    input  vs_mode_e              cfg_mode,
    output logic [LINE_IDX_W-1:0] line_idx,
    output logic [LINE_IDX_W-1:0] line_nxt,
    output logic [LINE_IDX_W-1:0] eff_lines,
    output vs_mode_e              eff_mode,
    output logic                  frame_wrap
);
    localparam logic [LINE_IDX_W-1:0] N_MIN = LINE_IDX_W'(MIN_LINES);

    logic [LINE_IDX_W-1:0] idx_q;
    logic [LINE_IDX_W-1:0] n_q;
    vs_mode_e              mode_q;
    logic [LINE_IDX_W-1:0] cfg_cl;

    // Raise frame lengths below the minimum.
    always_comb cfg_cl = (cfg_lines < N_MIN) ? N_MIN : cfg_lines;

    // Work out the next index and the configuration for the line being entered.
    always_comb begin
        frame_wrap = line_adv && (idx_q == n_q - 1'b1);
        eff_lines  = frame_wrap ? cfg_cl   : n_q;
        eff_mode   = frame_wrap ? cfg_mode : mode_q;
        if (!line_adv)       line_nxt = idx_q;
        else if (frame_wrap) line_nxt = '0;
        else                 line_nxt = idx_q + 1'b1;
    end

    // Hold the index and load the shadow configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            n_q    <= N_MIN;
            mode_q <= VS_PULSE;
        end else if (!run) begin
            idx_q  <= '0;
            n_q    <= cfg_cl;
            mode_q <= cfg_mode;
        end else begin
            idx_q <= line_nxt;
            if (frame_wrap) begin
                n_q    <= cfg_cl;
                mode_q <= cfg_mode;
            end
        end
    end

    always_comb line_idx = idx_q;

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < n_q);

    // R2
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line_adv && !frame_wrap) |=> (idx_q == $past(idx_q) + 1'b1));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_wrap) |=> ($stable(n_q) && $stable(mode_q)));

endmodule

// File: rtl/ts_fs_vsync_gen.sv
// VSYNC shaper. In pulse mode it is high for the last line of the frame. In
// toggle mode it inverts on entering the half-frame line and on the wrap.
// Assumes: line_nxt/eff_* describe the line entered on a line_adv edge.
module ts_fs_vsync_gen
    import ts_fs_pkg::*;
#(
    parameter int unsigned LINE_IDX_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  line_adv,
    input  logic [LINE_IDX_W-1:0] line_nxt,
    input  logic [LINE_IDX_W-1:0] eff_lines,
    input  vs_mode_e              eff_mode,
    output logic                  vsync
);
    logic                  vs_q;
    logic                  vs_nxt;
    logic [LINE_IDX_W-1:0] half_idx;
    logic [LINE_IDX_W-1:0] last_idx;

    // Line positions that carry an edge.
    always_comb begin
        half_idx = eff_lines >> 1;
        last_idx = eff_lines - 1'b1;
    end

    // Pick the level for the line being entered.
    always_comb begin
        unique case (eff_mode)
            VS_PULSE:  vs_nxt = (line_nxt == last_idx);
            VS_TOGGLE: vs_nxt = ((line_nxt == '0) || (line_nxt == half_idx)) ? ~vs_q : vs_q;
            default:   vs_nxt = 1'b0;
        endcase
    end

    // Register VSYNC; forced low in reset and while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            vs_q <= 1'b0;
        end else if (line_adv) begin
            vs_q <= vs_nxt;
        end
    end

    always_comb vsync = vs_q;

    // R1
    vs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !vs_q);

    // R9
    vs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !line_adv) |=> $stable(vs_q));

    // R4
    vs_pulse_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line_adv && eff_mode == VS_PULSE && line_nxt != last_idx) |=> !vs_q);

endmodule

// File: rtl/ts_fs_sync_chk.sv
// Sync-byte checker: compares each packet-start byte with the sync value and
// keeps a sticky flag on mismatch.
// Assumes: pkt_start marks the first byte slot of every packet in a line.
module ts_fs_sync_chk #(
    parameter logic [7:0] SYNC_BYTE = 8'h47
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_acc,
    input  logic       pkt_start,
    input  logic       chk_en,
    input  logic [7:0] byte_data,
    output logic       misalign
);
    logic mis_q;
    logic bad_byte;

    // Detect a checked packet-start byte that is not the sync value.
    always_comb bad_byte = byte_acc && chk_en && pkt_start && (byte_data != SYNC_BYTE);

    // Set the sticky flag; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mis_q <= 1'b0;
        end else if (bad_byte) begin
            mis_q <= 1'b1;
        end
    end

    always_comb misalign = mis_q;

    // R7
    mis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mis_q |=> mis_q);

    // R7
    mis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mis_q && (!chk_en || !byte_acc)) |=> !mis_q);

endmodule

// File: rtl/ts_field_sync.sv
// Transport-stream field sync generator top. It ties together the byte
// position tracker, the line counter with its config shadow, the VSYNC shaper
// and the sync-byte checker.
// Assumes: one byte per clock at most; configuration is stable around wraps.
module ts_field_sync
    import ts_fs_pkg::*;
#(
    parameter int unsigned PKT_BYTES     = 188,
    parameter int unsigned PKTS_PER_LINE = 2,
    parameter int unsigned LINE_IDX_W    = 10,
    parameter logic [7:0]  SYNC_BYTE     = 8'h47
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_data,
    input  logic [LINE_IDX_W-1:0] cfg_lines,
    input  logic                  cfg_mode,
    input  logic                  chk_en,
    output logic                  vsync,
    output logic [LINE_IDX_W-1:0] line_idx,
    output logic                  misalign
);
    logic                  byte_acc;
    logic                  pkt_start;
    logic                  line_last;
    logic                  line_adv;
    logic [LINE_IDX_W-1:0] line_nxt;
    logic [LINE_IDX_W-1:0] eff_lines;
    vs_mode_e              eff_mode;
    logic                  frame_wrap;

    // Qualify incoming bytes and line completions.
    always_comb begin
        byte_acc = enable && byte_vld;
        line_adv = byte_acc && line_last;
    end

    ts_fs_byte_ctr #(
        .PKT_BYTES    (PKT_BYTES),
        .PKTS_PER_LINE(PKTS_PER_LINE)
    ) u_byte_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .byte_acc (byte_acc),
        .pkt_start(pkt_start),
        .line_last(line_last)
    );

    ts_fs_line_ctr #(
        .LINE_IDX_W(LINE_IDX_W)
    ) u_line_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .line_adv  (line_adv),
        .cfg_lines (cfg_lines),
        .cfg_mode  (vs_mode_e'(cfg_mode)),
        .line_idx  (line_idx),
        .line_nxt  (line_nxt),
        .eff_lines (eff_lines),
        .eff_mode  (eff_mode),
        .frame_wrap(frame_wrap)
    );

    ts_fs_vsync_gen #(
        .LINE_IDX_W(LINE_IDX_W)
    ) u_vsync_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .line_adv (line_adv),
        .line_nxt (line_nxt),
        .eff_lines(eff_lines),
        .eff_mode (eff_mode),
        .vsync    (vsync)
    );

    ts_fs_sync_chk #(
        .SYNC_BYTE(SYNC_BYTE)
    ) u_sync_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_acc (byte_acc),
        .pkt_start(pkt_start),
        .chk_en   (chk_en),
        .byte_data(byte_data),
        .misalign (misalign)
    );

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_wrap) |=> (line_idx == '0));

endmodule

// File: tb/ts_field_sync_tb.sv
// Sweep bench: small line (2 packets of 4 bytes), both modes, several frame
// lengths, configuration changes in mid-frame, and sync-byte faults.
module ts_field_sync_tb;
    localparam int PKT  = 4;
    localparam int PPL  = 2;
    localparam int LB   = PKT * PPL;
    localparam int LW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = 8'h00;
    logic [LW-1:0] cfg_lines = LW'(4);
    logic          cfg_mode = 1'b0;
    logic          chk_en = 1'b0;
    logic          vsync;
    logic [LW-1:0] line_idx;
    logic          misalign;

    int errors = 0;
    int checks = 0;

    // Reference state
    int m_byte = 0;
    int m_line = 0;
    int m_n    = 2;
    int m_mode = 0;
    int m_vs   = 0;
    int m_mis  = 0;

    always #10 clk = ~clk;

    ts_field_sync #(
        .PKT_BYTES(PKT), .PKTS_PER_LINE(PPL), .LINE_IDX_W(LW), .SYNC_BYTE(8'h47)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .byte_vld(byte_vld),
        .byte_data(byte_data), .cfg_lines(cfg_lines), .cfg_mode(cfg_mode),
        .chk_en(chk_en), .vsync(vsync), .line_idx(line_idx), .misalign(misalign)
    );

    function automatic int clamp_n(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    task automatic model_idle_disabled();
        m_byte = 0; m_line = 0; m_vs = 0;
        m_n = clamp_n(int'(cfg_lines)); m_mode = int'(cfg_mode);
    endtask

    task automatic model_accept(input logic [7:0] d);
        if (chk_en && (m_byte % PKT == 0) && d != 8'h47) m_mis = 1;
        m_byte++;
        if (m_byte == LB) begin
            m_byte = 0;
            if (m_line == m_n - 1) begin
                m_line = 0;
                m_n = clamp_n(int'(cfg_lines));
                m_mode = int'(cfg_mode);
            end else begin
                m_line++;
            end
            if (m_mode == 0) m_vs = (m_line == m_n - 1) ? 1 : 0;
            else if (m_line == 0 || m_line == m_n / 2) m_vs = 1 - m_vs;
        end
    endtask

    task automatic check_all(input string tag);
        checks++;
        if (int'(line_idx) != m_line) begin
            errors++;
            $display("FAIL %s line_idx actual=%0d expected=%0d", tag, line_idx, m_line);
        end
        checks++;
        if (int'(vsync) != m_vs) begin
            errors++;
            $display("FAIL %s vsync actual=%0d expected=%0d (line %0d)", tag, vsync, m_vs, m_line);
        end
        checks++;
        if (int'(misalign) != m_mis) begin
            errors++;
            $display("FAIL %s misalign actual=%0d expected=%0d", tag, misalign, m_mis);
        end
    endtask

    // Drive one byte from a negedge; compare after the accepting edge.
    task automatic push(input logic [7:0] d, input string tag);
        byte_vld = 1'b1; byte_data = d;
        @(posedge clk);
        if (enable) model_accept(d); else model_idle_disabled();
        @(negedge clk);
        byte_vld = 1'b0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        @(posedge clk);
        if (!enable) model_idle_disabled();
        @(negedge clk);
        check_all(tag);
    endtask

    function automatic logic [7:0] good_byte(input int k);
        return (m_byte % PKT == 0) ? 8'h47 : 8'(k * 7 + 1);
    endfunction

    task automatic stream(input int cnt, input string tag);
        for (int k = 0; k < cnt; k++) begin
            push(good_byte(k), tag);
            if (k % 11 == 5) idle(tag);
        end
    endtask

    task automatic restart(input int n, input int mode, input string tag);
        enable = 1'b0; cfg_lines = LW'(n); cfg_mode = mode[0];
        idle(tag);
        enable = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ns[6];
        ns = '{1, 2, 3, 4, 5, 7};
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_idle_disabled();
        idle("R1");                     // R1 reset state
        // R1: bytes while disabled are ignored
        for (int k = 0; k < 2 * LB; k++) push(8'h47, "R1");

        // R2 R3 R4 R5: sweep both modes and several frame lengths (1 -> clamped to 2)
        for (int mode = 0; mode < 2; mode++) begin
            foreach (ns[i]) begin
                restart(ns[i], mode, ns[i] < 2 ? "R3" : "R2");
                stream(clamp_n(ns[i]) * LB * 2 + 3, mode == 0 ? "R4" : "R5");
            end
        end
        // R3: zero length also clamps
        restart(0, 0, "R3");
        stream(2 * LB * 2, "R3");

        // R6: mid-frame change waits for the wrap, pulse->toggle and back
        restart(4, 0, "R6");
        stream(10, "R6");
        cfg_lines = LW'(3); cfg_mode = 1'b1;
        stream(4 * LB + 3 * LB * 2, "R6");
        cfg_lines = LW'(5); cfg_mode = 1'b0;
        stream(3 * LB * 2 + 5 * LB, "R6");

        // R7: check disabled -> bad sync bytes ignored
        restart(3, 1, "R7");
        chk_en = 1'b0;
        for (int k = 0; k < 2 * LB; k++) push(8'h00, "R7");
        // R7: a bad byte in a non-start slot is ignored even with check on
        chk_en = 1'b1;
        stream(LB - m_byte, "R7");
        push(8'h47, "R7"); push(8'h13, "R7");
        stream(LB - m_byte, "R7");
        // R7 R8: second packet slot carries a bad sync byte; counting continues
        for (int k = 0; k < PKT; k++) push(good_byte(k), "R7");
        push(8'hB8, "R7");
        stream(3 * LB * 3, "R8");
        // R7: sticky across disable
        restart(2, 0, "R7");
        stream(LB * 3, "R7");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule